// File: doc/BRIEF.md
# One-Shot Buffer DMA Engine

This block copies a programmed number of bytes between a 4096-byte on-chip buffer and an external byte-wide memory, once per start command. Software loads a source address, a destination address and a byte count, then writes a command word that sets the run flag, picks the direction and may ask for a completion interrupt. Once the command is accepted the engine waits a fixed number of cycles. It then checks that the buffer-side range lies inside the buffer window. If the check passes, it moves the bytes one at a time over a request/acknowledge memory port.

The buffer is addressed by device addresses 0x40000 to 0x40FFF. The side of the transfer that touches the buffer is the destination when the direction bit is 0 and the source when it is 1, and that address has 0x40000 removed before it indexes the buffer. The external-side address is ANDed with a fixed address mask, which by default keeps 28 bits. While a transfer is pending or running, all four registers refuse writes and still answer reads. When the transfer ends, the run flag clears. If the command asked for it, a one-cycle interrupt request pulse follows.

Top module: `bufdma_engine`

## Requirements
- R1: After reset the source, destination, count and command registers all read 0, no memory request is raised and the interrupt output is low.
- R2: Register offsets are 0x80 source, 0x88 destination, 0x90 count and 0x98 command. An access with rq_size 8 reads or writes all 64 bits. With rq_size 4, a write stores the low 32 data bits zero-extended and a read returns the low 32 bits with the upper half zero. An access of any other size, or to any other offset, writes nothing, and such a read returns all ones. A read answer appears on rsp_valid/rsp_data in the cycle after the request.
- R3: Command bit 0 is run, bit 1 is direction (0 = external into buffer, 1 = buffer out to external) and bit 2 is interrupt enable. A command write with bit 0 clear changes nothing. A command read returns the stored bits 2..0 in bits 2..0 and the error flag in bit 31.
- R4: While run is set, writes to any of the four registers are ignored and reads still answer.
- R5: The first memory request comes exactly START_DELAY+1 cycles after the clock edge that accepts the command.
- R6: A transfer is accepted only if the buffer-side start S satisfies 0x40000 <= S < 0x41000, S+count > S, and S+count < 0x41000 (strictly below). A failing check moves no data, clears run, raises no interrupt and sets the error flag, which stays set until the next accepted command clears it.
- R7: With direction 0, byte i is read from external address (source+i) AND EXT_MASK and stored at buffer index destination-0x40000+i.
- R8: With direction 1, buffer byte source-0x40000+i is written to external address (destination+i) AND EXT_MASK.
- R9: One byte moves per cycle in which mem_req and mem_ack are both high. Each such move decrements the count register, which reads 0 afterwards, and run clears with the last move.
- R10: When a transfer completes with bit 2 set, irq_req is high for exactly one cycle. It stays low if bit 2 is clear or the range check failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Register access request |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_addr | input | 8 | Register byte offset |
| rq_size | input | 4 | Access size in bytes |
| rq_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read answer valid |
| rsp_data | output | 64 | Read answer data |
| mem_req | output | 1 | External byte request |
| mem_we | output | 1 | 1 = write to external, 0 = read |
| mem_addr | output | EXT_AW | Masked external byte address |
| mem_wdata | output | 8 | Byte written to external memory |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| irq_req | output | 1 | One-cycle completion interrupt |

## Verification
The buffer has no direct port, so its contents can only be seen by filling it with a memory-to-buffer transfer and draining it back with a buffer-to-memory transfer. The bench chains these pairs, including one that ends exactly one byte below the window end. Rejected ranges are hard to tell apart from slow ones. The stimulus therefore starts transfers that end exactly at the window end, that have zero length, and that start one byte below the window. It waits well past the start delay, treats any memory handshake as a miscompare, and then reads the error bit back. Writes that arrive during the delay window and are meant to be refused are issued straight after the start command, while run is already set.

// File: rtl/bufdma_pkg.sv
package bufdma_pkg;
    localparam logic [7:0] OFS_SRC = 8'h80;
    localparam logic [7:0] OFS_DST = 8'h88;
    localparam logic [7:0] OFS_CNT = 8'h90;
    localparam logic [7:0] OFS_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IEN = 2;
    localparam int CMD_ERR = 31;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_XFER = 2'd2
    } phase_e;
endpackage

// File: rtl/bufdma_window_check.sv
module bufdma_window_check #(
    parameter logic [63:0] BASE = 64'h40000,
    parameter int          SIZE = 4096,
    localparam int         IW   = $clog2(SIZE)
) (
    input  logic [63:0]   start,
    input  logic [63:0]   len,
    output logic          ok,
    output logic [IW-1:0] offset
);
    localparam logic [64:0] LIM     = {1'b0, BASE} + 65'(SIZE);
    localparam logic [IW-1:0] BASE_LO = BASE[IW-1:0];

    logic [64:0] s_ext;
    logic [64:0] e_ext;

    always_comb begin
        s_ext  = {1'b0, start};
        e_ext  = s_ext + {1'b0, len};
        ok     = (s_ext >= {1'b0, BASE}) && (s_ext < LIM)
              && (e_ext > s_ext) && (e_ext < LIM);
        offset = start[IW-1:0] - BASE_LO;
    end
endmodule

// File: rtl/bufdma_byte_buf.sv
module bufdma_byte_buf #(
    parameter int DEPTH = 4096,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/bufdma_engine.sv
module bufdma_engine
    import bufdma_pkg::*;
#(
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] BUF_BASE    = 64'h40000,
    parameter logic [63:0] EXT_MASK    = 64'h0FFF_FFFF,
    parameter int          EXT_AW      = 32,
    parameter int          START_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_valid,
    input  logic              rq_write,
    input  logic [7:0]        rq_addr,
    input  logic [3:0]        rq_size,
    input  logic [63:0]       rq_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [EXT_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              irq_req
);
    localparam int IW = $clog2(BUF_BYTES);
    localparam int DW = $clog2(START_DELAY + 2);

    typedef struct packed {
        logic [63:0]   src;
        logic [63:0]   dst;
        logic [63:0]   cnt;
        logic [2:0]    cmd;
        logic          err;
        phase_e        phase;
        logic [DW-1:0] dly;
        logic [63:0]   ext;
        logic [IW-1:0] idx;
        logic          irq;
        logic          rsp_v;
        logic [63:0]   rsp_d;
    } state_t;

    state_t q, d;

    logic          win_ok;
    logic [IW-1:0] win_ofs;
    logic [63:0]   win_start;
    logic          buf_we;
    logic [7:0]    buf_rd;
    logic          size_ok;
    logic [63:0]   wval;
    logic [63:0]   rv;

    assign win_start = q.cmd[CMD_DIR] ? q.src : q.dst;

    bufdma_window_check #(
        .BASE (BUF_BASE),
        .SIZE (BUF_BYTES)
    ) u_win (
        .start  (win_start),
        .len    (q.cnt),
        .ok     (win_ok),
        .offset (win_ofs)
    );

    bufdma_byte_buf #(
        .DEPTH (BUF_BYTES)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.idx),
        .wdata (mem_rdata),
        .raddr (q.idx),
        .rdata (buf_rd)
    );

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        d.rsp_v = 1'b0;
        buf_we  = 1'b0;
        size_ok = (rq_size == 4'd4) || (rq_size == 4'd8);
        wval    = (rq_size == 4'd4) ? {32'h0, rq_wdata[31:0]} : rq_wdata;
        rv      = '1;

        // register reads
        if (rq_valid && !rq_write) begin
            d.rsp_v = 1'b1;
            if (size_ok) begin
                unique case (rq_addr)
                    OFS_SRC: rv = q.src;
                    OFS_DST: rv = q.dst;
                    OFS_CNT: rv = q.cnt;
                    OFS_CMD: rv = {32'h0, q.err, 28'h0, q.cmd};
                    default: rv = '1;
                endcase
                if (rq_size == 4'd4 && (rq_addr == OFS_SRC || rq_addr == OFS_DST
                                        || rq_addr == OFS_CNT || rq_addr == OFS_CMD)) begin
                    rv = {32'h0, rv[31:0]};
                end
            end
            d.rsp_d = rv;
        end

        // register writes, refused while run is set
        if (rq_valid && rq_write && size_ok && !q.cmd[CMD_RUN]) begin
            unique case (rq_addr)
                OFS_SRC: d.src = wval;
                OFS_DST: d.dst = wval;
                OFS_CNT: d.cnt = wval;
                OFS_CMD: begin
                    if (wval[CMD_RUN]) begin
                        d.cmd   = wval[2:0];
                        d.err   = 1'b0;
                        d.phase = PH_WAIT;
                        d.dly   = DW'(START_DELAY);
                    end
                end
                default: ;
            endcase
        end

        // transfer sequencing
        unique case (q.phase)
            PH_WAIT: begin
                if (q.dly == '0) begin
                    if (win_ok) begin
                        d.phase = PH_XFER;
                        d.idx   = win_ofs;
                        d.ext   = q.cmd[CMD_DIR] ? q.dst : q.src;
                    end else begin
                        d.phase        = PH_IDLE;
                        d.err          = 1'b1;
                        d.cmd[CMD_RUN] = 1'b0;
                    end
                end else begin
                    d.dly = q.dly - DW'(1);
                end
            end
            PH_XFER: begin
                if (mem_ack) begin
                    buf_we = !q.cmd[CMD_DIR];
                    d.idx  = q.idx + IW'(1);
                    d.ext  = q.ext + 64'd1;
                    d.cnt  = q.cnt - 64'd1;
                    if (q.cnt == 64'd1) begin
                        d.phase        = PH_IDLE;
                        d.cmd[CMD_RUN] = 1'b0;
                        d.irq          = q.cmd[CMD_IEN];
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_d;
    assign mem_req   = (q.phase == PH_XFER);
    assign mem_we    = q.cmd[CMD_DIR];
    assign mem_addr  = EXT_AW'(q.ext & EXT_MASK);
    assign mem_wdata = buf_rd;
    assign irq_req   = q.irq;

    // cycles spent waiting, kept only for the delay check below
    logic [DW-1:0] wt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else if (q.phase == PH_WAIT) begin
            wt_q <= wt_q + DW'(1);
        end else begin
            wt_q <= '0;
        end
    end

    assert_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_WAIT && $past(q.phase) == PH_WAIT) |-> $past(wt_q) == DW'(START_DELAY))
        else $error("start delay length wrong");

    assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_write && q.cmd[CMD_RUN]) |=> ($stable(q.src) && $stable(q.dst)))
        else $error("register changed while running");

    assert_req_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> q.cmd[CMD_RUN])
        else $error("memory request without run");

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> q.cnt == $past(q.cnt) - 64'd1)
        else $error("count did not step by one");

    assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!q.cmd[CMD_RUN] && $past(mem_req) && $past(mem_ack)))
        else $error("interrupt outside completion");

    assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> (!q.cmd[CMD_RUN] && !irq_req && !$past(mem_req)))
        else $error("range abort misbehaved");
endmodule

// File: tb/bufdma_engine_tb.sv
module bufdma_engine_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_valid = 1'b0;
    logic        rq_write = 1'b0;
    logic [7:0]  rq_addr = '0;
    logic [3:0]  rq_size = '0;
    logic [63:0] rq_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        irq_req;

    always #5 clk = ~clk;

    bufdma_engine #(.START_DELAY(D)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rq_valid(rq_valid), .rq_write(rq_write), .rq_addr(rq_addr),
        .rq_size(rq_size), .rq_wdata(rq_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_req(irq_req)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [7:0]  data;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int pat = 0;
    bit finished = 1'b0;

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            mem_ack   = mem_req && ((pat % 3) != 1);
            mem_rdata = mem_addr[7:0] ^ 8'h5A;
            pat++;
            if (mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R6: unexpected handshake addr %h expected none", mem_addr);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check("R7/R8 direction", {63'h0, mem_we}, {63'h0, e.we});
                    check("R7/R8 masked address", {32'h0, mem_addr}, {32'h0, e.addr});
                    if (e.we) check("R8 buffer byte", {56'h0, mem_wdata}, {56'h0, e.data});
                end
            end
            if (irq_req) irq_seen++;
        end
    end

    task automatic reg_wr(logic [7:0] a, logic [3:0] sz, logic [63:0] v);
        @(negedge clk);
        rq_valid = 1'b1; rq_write = 1'b1; rq_addr = a; rq_size = sz; rq_wdata = v;
        @(negedge clk);
        rq_valid = 1'b0; rq_write = 1'b0;
    endtask

    task automatic reg_rd(logic [7:0] a, logic [3:0] sz, output logic [63:0] v);
        @(negedge clk);
        rq_valid = 1'b1; rq_write = 1'b0; rq_addr = a; rq_size = sz;
        @(negedge clk);
        rq_valid = 1'b0;
        v = rsp_valid ? rsp_data : 64'hDEAD;
    endtask

    // driver: push expected handshakes for a transfer
    task automatic expect_xfer(bit dir, logic [63:0] ext, int n, logic [7:0] seed_lo);
        for (int i = 0; i < n; i++) begin
            item_t e;
            logic [63:0] a;
            a = (ext + 64'(i)) & 64'h0FFF_FFFF;
            e.we = dir;
            e.addr = a[31:0];
            e.data = (seed_lo + 8'(i)) ^ 8'h5A;
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_idle(output logic [63:0] cmdv);
        cmdv = '1;
        for (int k = 0; k < 500; k++) begin
            reg_rd(8'h98, 4'd8, cmdv);
            if (!cmdv[0]) break;
        end
    endtask

    task automatic setup(logic [63:0] s, logic [63:0] dd, logic [63:0] c);
        reg_wr(8'h80, 4'd8, s);
        reg_wr(8'h88, 4'd8, dd);
        reg_wr(8'h90, 4'd8, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int lows;
        int irq0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 req low", {63'h0, mem_req}, 64'h0);
        check("R1 irq low", {63'h0, irq_req}, 64'h0);
        reg_rd(8'h80, 4'd8, v); check("R1 src", v, 64'h0);
        reg_rd(8'h88, 4'd8, v); check("R1 dst", v, 64'h0);
        reg_rd(8'h90, 4'd8, v); check("R1 cnt", v, 64'h0);
        reg_rd(8'h98, 4'd8, v); check("R1 cmd", v, 64'h0);

        // R2 access sizes and offsets
        reg_wr(8'h80, 4'd8, 64'h1122_3344_5566_7788);
        reg_rd(8'h80, 4'd8, v); check("R2 64-bit rw", v, 64'h1122_3344_5566_7788);
        reg_rd(8'h80, 4'd4, v); check("R2 32-bit read", v, 64'h5566_7788);
        reg_wr(8'h80, 4'd2, 64'h0);
        reg_rd(8'h80, 4'd8, v); check("R2 size-2 write ignored", v, 64'h1122_3344_5566_7788);
        reg_rd(8'h80, 4'd1, v); check("R2 size-1 read all ones", v, '1);
        reg_wr(8'h88, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD);
        reg_rd(8'h88, 4'd8, v); check("R2 32-bit write zero-extends", v, 64'hCCCC_DDDD);
        reg_rd(8'h40, 4'd8, v); check("R2 unmapped read", v, '1);

        // R3 command without run
        reg_wr(8'h98, 4'd8, 64'h6);
        reg_rd(8'h98, 4'd8, v); check("R3 no-run command ignored", v, 64'h0);

        // transfer A: external -> buffer, masked source, interrupt on
        setup(64'h0000_0100_1000_0100, 64'h40010, 64'd8);
        expect_xfer(1'b0, 64'h0000_0100_1000_0100, 8, 8'h00);
        irq0 = irq_seen;
        reg_wr(8'h98, 4'd8, 64'h5);
        lows = 1;
        // R4 writes refused during the delay window
        rq_valid = 1'b1; rq_write = 1'b1; rq_addr = 8'h80; rq_size = 4'd8; rq_wdata = 64'h0;
        @(negedge clk); lows++;
        rq_valid = 1'b0; rq_write = 1'b0;
        while (!mem_req && lows < 1000) begin @(negedge clk); if (!mem_req) lows++; end
        check("R5 start delay cycles", 64'(lows), 64'(D + 1));
        wait_idle(v);
        check("R3 cmd after done", v, 64'h4);
        reg_rd(8'h80, 4'd8, v); check("R4 src unchanged", v, 64'h0000_0100_1000_0100);
        reg_rd(8'h90, 4'd8, v); check("R9 count reaches zero", v, 64'h0);
        check("R7 all handshakes consumed", 64'(exp_q.size()), 64'h0);
        repeat (2) @(negedge clk);
        check("R10 one irq pulse", 64'(irq_seen - irq0), 64'd1);

        // transfer B: buffer -> external, masked destination, no interrupt
        setup(64'h40010, 64'hF000_2000, 64'd8);
        expect_xfer(1'b1, 64'hF000_2000, 8, 8'h00);
        irq0 = irq_seen;
        reg_wr(8'h98, 4'd8, 64'h3);
        wait_idle(v);
        check("R8 cmd after done", v, 64'h2);
        check("R8 all handshakes consumed", 64'(exp_q.size()), 64'h0);
        repeat (2) @(negedge clk);
        check("R10 no irq when disabled", 64'(irq_seen - irq0), 64'd0);

        // R6 range ends exactly at window end: rejected
        irq0 = irq_seen;
        setup(64'h40FF8, 64'h700, 64'd8);
        reg_wr(8'h98, 4'd8, 64'h7);
        repeat (D + 10) @(negedge clk);
        reg_rd(8'h98, 4'd8, v); check("R6 end at window end aborts", v, 64'h8000_0006);
        reg_rd(8'h90, 4'd8, v); check("R6 count untouched", v, 64'd8);
        check("R6 no irq on abort", 64'(irq_seen - irq0), 64'd0);

        // R6 zero count rejected
        setup(64'h0, 64'h40000, 64'd0);
        reg_wr(8'h98, 4'd8, 64'h1);
        wait_idle(v); check("R6 zero count aborts", v, 64'h8000_0000);

        // R6 start just below window rejected
        setup(64'h0, 64'h3FFFF, 64'd1);
        reg_wr(8'h98, 4'd8, 64'h1);
        wait_idle(v); check("R6 start below window aborts", v, 64'h8000_0000);

        // R6 last legal range, error cleared by accepted command
        setup(64'h300, 64'h40FF8, 64'd7);
        expect_xfer(1'b0, 64'h300, 7, 8'h00);
        reg_wr(8'h98, 4'd8, 64'h1);
        wait_idle(v); check("R6 boundary accepted, error cleared", v, 64'h0);
        setup(64'h40FF8, 64'h500, 64'd7);
        expect_xfer(1'b1, 64'h500, 7, 8'h00);
        reg_wr(8'h98, 4'd8, 64'h3);
        wait_idle(v); check("R8 boundary drain done", v, 64'h2);
        check("R8 boundary handshakes consumed", 64'(exp_q.size()), 64'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule